// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit adder. It adds two operands and a carry-in, and it returns a 16-bit sum and a carry-out. The carry never ripples. Each 4-bit slice forms bit-level generate (AND) and propagate (OR) terms. A lookahead unit then turns those terms into the carry for every bit of the slice, written as a flat sum of products. The same lookahead unit, fed with the four slice-level generate and propagate pairs, produces the carry into each slice and the final carry-out.

The block also exports its own block generate and block propagate. Four copies can then sit under a third lookahead level to make a 64-bit adder. The design has no clock and no state: the outputs follow the inputs within the same cycle.

Top module: `cla16_adder`

## Requirements
- R1: `{c_o, sum_o}` equals the 17-bit value `a_i + b_i + c_i` for every operand pair and carry-in.
- R2: When both operands and `c_i` are zero, `sum_o` and `c_o` are zero.
- R3: A carry entering at bit 0 travels across all 16 positions. With `a_i` = 16'hFFFF, `b_i` = 0 and `c_i` = 1, the result is `sum_o` = 0 and `c_o` = 1.
- R4: `p_o` is 1 exactly when every bit position has at least one operand bit set, that is when `(a_i | b_i)` is 16'hFFFF.
- R5: `g_o` equals the carry-out that the same operands would produce with `c_i` = 0.
- R6: `c_o` equals `g_o | (p_o & c_i)` for all inputs.
- R7: The block holds no state. After any change of inputs, the outputs sampled in the same cycle match R1, whatever the previous inputs were.
- R8: The least significant 4-bit slice is correct for all 512 combinations of its two 4-bit operands and the carry-in, with the upper operand bits held at zero. Bits 4 and up of the sum then carry only the slice's carry-out in bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum |
| c_o | output | 1 | Carry out of bit 15 |
| g_o | output | 1 | Block generate, for a higher lookahead level |
| p_o | output | 1 | Block propagate, for a higher lookahead level |

## Verification
The block is combinational, so a wrong carry term shows at the ports in the same cycle as the stimulus that needs it, and at no other time. The error is a sum bit flipped at the slice that received the carry, or a wrong `c_o`. A fault in a slice-level generate or propagate also shows on `g_o`, `p_o` or `c_o`, but only for operands whose carry must cross that slice boundary. Full-propagate patterns such as all-ones plus a carry-in are therefore the quickest way to expose it.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  localparam int unsigned GRP_W    = 4;
  localparam int unsigned N_GRP    = 4;
  localparam int unsigned ADD_W    = GRP_W * N_GRP;
endpackage

// File: rtl/cla_unit.sv
`timescale 1ns/1ps
// Flat lookahead: every carry is a two-level sum of products of g, p, c_i.
module cla_unit #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         c_i,
  output logic [W:1]   c_o,
  output logic         g_o,
  output logic         p_o
);
  always_comb begin
    logic acc;
    logic term;
    for (int k = 1; k <= W; k++) begin
      term = c_i;
      for (int j = 0; j < k; j++) term = term & p_i[j];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m < k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      c_o[k] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = g_i[j];
      for (int m = j + 1; m < W; m++) term = term & p_i[m];
      acc = acc | term;
    end
    g_o = acc;
    p_o = &p_i;
  end

  // flat carries must agree with the recursive chain form
  always_comb begin
    for (int k = 1; k <= W; k++) begin
      p_carry_chain_r3: assert (c_o[k] == (g_i[k-1] | (p_i[k-1] & ((k == 1) ? c_i : c_o[(k > 1) ? k-1 : 1]))))
        else $error("carry chain mismatch at %0d", k);
    end
  end
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         g_o,
  output logic         p_o
);
  logic [W-1:0] bit_g, bit_p;
  logic [W:0]   carry;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;   // OR propagate: sum must use a^b, not p
  assign carry[0] = c_i;

  cla_unit #(.W(W)) u_la (
    .g_i (bit_g),
    .p_i (bit_p),
    .c_i (c_i),
    .c_o (carry[W:1]),
    .g_o (g_o),
    .p_o (p_o)
  );

  assign sum_o = a_i ^ b_i ^ carry[W-1:0];

  always_comb begin
    p_grp_add_r8: assert ({carry[W], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("group sum mismatch");
    p_grp_cout_r6: assert (carry[W] == (g_o | (p_o & c_i)))
      else $error("group carry-out vs G/P mismatch");
  end
endmodule

// File: rtl/cla16_adder.sv
`timescale 1ns/1ps
module cla16_adder
  import cla_pkg::*;
(
  input  logic [ADD_W-1:0] a_i,
  input  logic [ADD_W-1:0] b_i,
  input  logic             c_i,
  output logic [ADD_W-1:0] sum_o,
  output logic             c_o,
  output logic             g_o,
  output logic             p_o
);
  logic [N_GRP-1:0] grp_g, grp_p;
  logic [N_GRP:0]   grp_c;

  assign grp_c[0] = c_i;

  for (genvar i = 0; i < N_GRP; i++) begin : g_grp
    cla_group #(.W(GRP_W)) u_grp (
      .a_i   (a_i[i*GRP_W +: GRP_W]),
      .b_i   (b_i[i*GRP_W +: GRP_W]),
      .c_i   (grp_c[i]),
      .sum_o (sum_o[i*GRP_W +: GRP_W]),
      .g_o   (grp_g[i]),
      .p_o   (grp_p[i])
    );
  end

  // second lookahead level: carries into each group
  cla_unit #(.W(N_GRP)) u_top_la (
    .g_i (grp_g),
    .p_i (grp_p),
    .c_i (c_i),
    .c_o (grp_c[N_GRP:1]),
    .g_o (g_o),
    .p_o (p_o)
  );

  assign c_o = grp_c[N_GRP];

  always_comb begin
    p_add_r1: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{ADD_W{1'b0}}, c_i}))
      else $error("sum mismatch");
    p_export_r6: assert (c_o == (g_o | (p_o & c_i)))
      else $error("carry-out vs exported G/P mismatch");
    p_prop_r4: assert (p_o == ((a_i | b_i) == {ADD_W{1'b1}}))
      else $error("block propagate mismatch");
  end
endmodule

// File: tb/cla16_adder_test.sv
`timescale 1ns/1ps
module cla16_adder_test;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout, gx, px;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cla16_adder uut (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(sum), .c_o(cout), .g_o(gx), .p_o(px)
  );

  // {a, b, cin, expected {cout,sum}}
  localparam logic [49:0] VEC [8] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h0_0000},
    {16'hFFFF, 16'h0000, 1'b1, 17'h1_0000},
    {16'hFFFF, 16'h0001, 1'b0, 17'h1_0000},
    {16'h1234, 16'h4321, 1'b0, 17'h0_5555},
    {16'h8000, 16'h8000, 1'b0, 17'h1_0000},
    {16'h7FFF, 16'h0001, 1'b1, 17'h0_8001},
    {16'hABCD, 16'h1111, 1'b1, 17'h0_BCDF},
    {16'hF0F0, 16'h0F0F, 1'b1, 17'h1_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic full_check(input string req);
    logic [16:0] ref_sum;
    logic [16:0] ref_g;
    ref_sum = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    ref_g   = {1'b0, a} + {1'b0, b};
    chk(req, {15'd0, cout, sum}, {15'd0, ref_sum});
    chk("R4", {31'd0, px}, {31'd0, ((a | b) == 16'hFFFF)});
    chk("R5", {31'd0, gx}, {31'd0, ref_g[16]});
    chk("R6", {31'd0, cout}, {31'd0, gx | (px & cin)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R2: idle state
    @(negedge clk);
    chk("R2", {15'd0, cout, sum}, 32'd0);

    // R1: vector table
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      chk("R1", {15'd0, cout, sum}, {15'd0, VEC[i][16:0]});
    end

    // R3: full propagation, all-ones plus carry-in and all-ones plus one with carry-in
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R3", {15'd0, cout, sum}, 32'h0001_0000);
    apply(16'hFFFF, 16'h0001, 1'b1);
    chk("R3", {15'd0, cout, sum}, 32'h0001_0001);
    chk("R4", {31'd0, px}, 32'd1);
    chk("R5", {31'd0, gx}, 32'd1);

    // R4/R5/R6 boundaries of the exported terms
    apply(16'hAAAA, 16'h5555, 1'b0);
    chk("R4", {31'd0, px}, 32'd1);
    chk("R5", {31'd0, gx}, 32'd0);
    chk("R6", {31'd0, cout}, 32'd0);
    apply(16'hAAAA, 16'h5555, 1'b1);
    chk("R6", {31'd0, cout}, 32'd1);
    apply(16'h7FFF, 16'h7FFF, 1'b1);
    chk("R4", {31'd0, px}, 32'd0);

    // R8: exhaustive low slice
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          apply(16'(x), 16'(y), c[0]);
          chk("R8", {15'd0, cout, sum}, 32'(x + y + c));
        end

    // R7: random operands, each step independent of the last
    for (int i = 0; i < 2000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      full_check("R7");
    end

    // R2 again after activity
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R2", {15'd0, cout, sum}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule